// File: doc/BRIEF.md
# Selectable Square-Wave Output

This block turns a one-byte control setting into the level of an open-drain output pin. With the wave enabled, the pin toggles at one of four rates derived from a free-running prescaler. That prescaler is advanced by `ref_tick`, an enable that pulses twice per 32.768 kHz oscillator period, so it runs at 65.536 kHz. With the wave disabled, the pin holds a static level taken from the control byte. The same prescaler also produces a one-cycle strobe once per second, and the timekeeping logic uses that strobe to advance its counters.

The control byte is written with `cfg_we`/`cfg_wdata` and read back on `cfg_rdata`. A write lands in a shadow copy at once. The active setting follows the shadow only on an edge of the tap that the new setting selects, so a change of rate or enable never produces a runt pulse. When both the old and the new setting have the wave disabled, a level change takes effect at once. The pin output `sqw_pull_low` is the drive enable of the open-drain pad: 1 pulls the pin low, and 0 releases it so that it reads high.

Top module: `sqw_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first write, `sqw_pull_low` is 1, `cfg_rdata` is 0x00 and `sec_strobe` is 0.
- R2: `cfg_rdata` returns the last written values of bit 7 (static level), bit 4 (wave enable) and bits 1:0 (rate code).
- R3: With the wave disabled (bit 4 = 0), the pin follows bit 7: level 1 gives `sqw_pull_low` = 0, and level 0 gives `sqw_pull_low` = 1. When the wave was already disabled, a new level appears within 4 clock cycles of the write.
- R4: With the wave enabled and `ref_tick` high every cycle, the output half-period in `ref_tick` pulses is 1 for rate code 11 (32.768 kHz), 4 for code 10 (8.192 kHz), 8 for code 01 (4.096 kHz) and 2^(CNT_W-1) for code 00 (1 Hz).
- R5: Only `ref_tick` advances the prescaler. With `ref_tick` high every second cycle, every half-period in clock cycles doubles.
- R6: `sec_strobe` is a one-cycle pulse once every 2^CNT_W `ref_tick` pulses, whatever the control byte holds.
- R7: With the wave enabled at rate code 00, every `sec_strobe` pulse falls in the same cycle as a falling edge of the wave, which is the cycle in which `sqw_pull_low` rises.
- R8: A change of rate or enable reaches the pin only on an edge of the newly selected tap. After a switch from code 01 to code 10, no output level lasts fewer than 4 `ref_tick` pulses.
- R9: Bits 6, 5, 3 and 2 of a write are ignored. They read back as 0 and do not change the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick | input | 1 | Prescaler advance enable, two pulses per 32.768 kHz period |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Control byte readback |
| sqw_pull_low | output | 1 | Open-drain pad enable: 1 pulls the pin low |
| sec_strobe | output | 1 | One-cycle pulse per second for the clock counters |

## Verification
The hardest case to reach is a rate switch issued partway through a phase of the old tap. A block that switched at once would leave a runt level only for some write offsets. The bench therefore repeats the switch from code 01 to code 10 at eight successive offsets within the prescaler phase. It records every interval between output transitions across each switch and checks the shortest one. Alignment of the one-second strobe with the 1 Hz falling edge is checked on several consecutive seconds, using the bench's own record of the previous pin level.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  typedef enum logic [1:0] {
    RS_1HZ  = 2'b00,
    RS_4K   = 2'b01,
    RS_8K   = 2'b10,
    RS_32K  = 2'b11
  } rate_e;

  typedef struct packed {
    logic  lvl;
    logic  en;
    rate_e rs;
  } sqw_cfg_t;

  localparam int unsigned NUM_RATES = 4;

  // prescaler bit that carries the wave for each rate code
  function automatic int unsigned tap_pos(input int unsigned code, input int unsigned cnt_w);
    case (code)
      3:       return 0;
      2:       return 2;
      1:       return 3;
      default: return cnt_w - 1;
    endcase
  endfunction

  function automatic logic [7:0] cfg_encode(input sqw_cfg_t c);
    return {c.lvl, 2'b00, c.en, 2'b00, c.rs};
  endfunction

  function automatic sqw_cfg_t cfg_decode(input logic [7:0] b);
    sqw_cfg_t c;
    c.lvl = b[7];
    c.en  = b[4];
    c.rs  = rate_e'(b[1:0]);
    return c;
  endfunction

endpackage

// File: rtl/sqw_prescaler.sv
module sqw_prescaler
  import sqw_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  output logic [NUM_RATES-1:0] tap_lvl,
  output logic [NUM_RATES-1:0] tap_flip
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // one tap per rate code; a tap flips when every bit below it is set
  for (genvar r = 0; r < NUM_RATES; r++) begin : g_tap
    localparam int unsigned K = tap_pos(r, CNT_W);
    assign tap_lvl[r] = cnt_q[K];
    if (K == 0) begin : g_lsb
      assign tap_flip[r] = tick;
    end else begin : g_carry
      assign tap_flip[r] = tick & (&cnt_q[K-1:0]);
    end
  end

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  // R5
  flip_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_flip != '0) |-> tick);

endmodule

// File: rtl/sqw_cfg.sv
module sqw_cfg
  import sqw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [7:0]           wdata,
  input  logic [NUM_RATES-1:0] tap_flip,
  output sqw_cfg_t             sh_q,
  output sqw_cfg_t             act_q,
  output sqw_cfg_t             act_nxt
);

  sqw_cfg_t sh_d;
  logic     pending;
  logic     new_edge;
  logic     both_off;
  logic     commit;

  always_comb begin
    sh_d = sh_q;
    if (we) begin
      sh_d = cfg_decode(wdata);
    end
  end

  always_comb begin
    pending  = (sh_q != act_q);
    new_edge = tap_flip[sh_q.rs];
    both_off = !sh_q.en && !act_q.en;
    commit   = pending && (new_edge || both_off);
    act_nxt  = commit ? sh_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      act_q <= '0;
    end else begin
      sh_q  <= sh_d;
      act_q <= act_nxt;
    end
  end

  // R8
  act_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(new_edge || both_off));

  // R9
  rsvd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && ((wdata & 8'h93) == cfg_encode(sh_q))) |=> $stable(sh_q));

endmodule

// File: rtl/sqw_outstage.sv
module sqw_outstage
  import sqw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RATES-1:0] tap_lvl,
  input  logic [NUM_RATES-1:0] tap_flip,
  input  sqw_cfg_t             act_q,
  input  sqw_cfg_t             act_nxt,
  output logic                 wave_q,
  output logic                 sec_q
);

  logic [NUM_RATES-1:0] tap_nxt;
  logic                 wave_d;
  logic                 sec_d;

  always_comb begin
    tap_nxt = tap_lvl ^ tap_flip;
    wave_d  = act_nxt.en ? tap_nxt[act_nxt.rs] : act_nxt.lvl;
    sec_d   = tap_flip[RS_1HZ] & tap_lvl[RS_1HZ];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q <= 1'b0;
      sec_q  <= 1'b0;
    end else begin
      wave_q <= wave_d;
      sec_q  <= sec_d;
    end
  end

  // R6
  sec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q |=> !sec_q);

  // R7
  sec_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q && act_q.en && (act_q.rs == RS_1HZ) &&
     $past(act_q.en && (act_q.rs == RS_1HZ))) |-> $fell(wave_q));

  // R3
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q.en && $stable(act_q)) |-> (wave_q == act_q.lvl));

endmodule

// File: rtl/sqw_gen.sv
module sqw_gen
  import sqw_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic       sqw_pull_low,
  output logic       sec_strobe
);

  logic                 rst_meta;
  logic                 rst_sync;
  logic [NUM_RATES-1:0] tap_lvl;
  logic [NUM_RATES-1:0] tap_flip;
  sqw_cfg_t             sh_q;
  sqw_cfg_t             act_q;
  sqw_cfg_t             act_nxt;
  logic                 wave_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  sqw_prescaler #(.CNT_W(CNT_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_sync),
    .tick     (ref_tick),
    .tap_lvl  (tap_lvl),
    .tap_flip (tap_flip)
  );

  sqw_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .tap_flip (tap_flip),
    .sh_q     (sh_q),
    .act_q    (act_q),
    .act_nxt  (act_nxt)
  );

  sqw_outstage u_out (
    .clk      (clk),
    .rst_n    (rst_sync),
    .tap_lvl  (tap_lvl),
    .tap_flip (tap_flip),
    .act_q    (act_q),
    .act_nxt  (act_nxt),
    .wave_q   (wave_q),
    .sec_q    (sec_strobe)
  );

  assign cfg_rdata    = cfg_encode(sh_q);
  assign sqw_pull_low = ~wave_q;

  // R2
  rdata_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (cfg_rdata & 8'h6C) == 8'h00);

  // R1
  reset_pin_chk: assert property (@(posedge clk)
    !rst_sync |-> (sqw_pull_low && !sec_strobe));

endmodule

// File: tb/sqw_gen_tb.sv
module sqw_gen_tb;

  localparam int unsigned CNT_W = 6;

  logic       clk;
  logic       rst_n;
  logic       ref_tick;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       sqw_pull_low;
  logic       sec_strobe;

  int n_checks;
  int n_fails;
  int tick_gap;
  int gap_ctr;
  bit done;

  sqw_gen #(.CNT_W(CNT_W)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_tick     (ref_tick),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .sqw_pull_low (sqw_pull_low),
    .sec_strobe   (sec_strobe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    ref_tick = 1'b0;
    gap_ctr  = 0;
    tick_gap = 1;
  end

  always @(negedge clk) begin
    gap_ctr = gap_ctr + 1;
    if (gap_ctr >= tick_gap) begin
      gap_ctr  = 0;
      ref_tick = 1'b1;
    end else begin
      ref_tick = 1'b0;
    end
  end

  task automatic check_eq(input string tag, input int got, input int exp_v);
    n_checks++;
    if (got != exp_v) begin
      n_fails++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp_v, exp_v);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure_half(input int exp_c, input string tag);
    logic prev;
    int   cnt;
    int   t;
    @(negedge clk);
    prev = sqw_pull_low;
    t = 0;
    while (sqw_pull_low == prev && t < 400) begin
      @(negedge clk);
      t++;
    end
    for (int n = 0; n < 3; n++) begin
      prev = sqw_pull_low;
      cnt = 0;
      do begin
        @(negedge clk);
        cnt++;
      end while (sqw_pull_low == prev && cnt < 400);
      check_eq(tag, cnt, exp_c);
    end
  endtask

  task automatic hold_level(input logic exp_v, input int n, input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sqw_pull_low != exp_v) bad++;
    end
    check_eq(tag, bad, 0);
  endtask

  task automatic t_reset;
    rst_n     = 1'b0;
    cfg_we    = 1'b0;
    cfg_wdata = 8'h00;
    idle(3);
    check_eq("R1 pin during reset", sqw_pull_low, 1);
    check_eq("R1 rdata during reset", cfg_rdata, 0);
    check_eq("R1 strobe during reset", sec_strobe, 0);
    rst_n = 1'b1;
    idle(10);
    hold_level(1'b1, 30, "R1 pin low after reset");
    check_eq("R1 rdata after reset", cfg_rdata, 0);
  endtask

  task automatic t_readback;
    write_cfg(8'h93);
    check_eq("R2 readback 0x93", cfg_rdata, 8'h93);
    write_cfg(8'h12);
    check_eq("R2 readback 0x12", cfg_rdata, 8'h12);
    write_cfg(8'hFF);
    check_eq("R9 readback of 0xFF", cfg_rdata, 8'h93);
  endtask

  task automatic t_static;
    // enabled at code 11 -> disabled with level 1, code 00: commits on a 1 Hz tap edge
    write_cfg(8'h80);
    idle(80);
    hold_level(1'b0, 20, "R3 level 1 releases pin");
    write_cfg(8'h00);
    idle(4);
    check_eq("R3 level 0 within 4 cycles", sqw_pull_low, 1);
    write_cfg(8'h80);
    idle(4);
    check_eq("R3 level 1 within 4 cycles", sqw_pull_low, 0);
  endtask

  task automatic t_rsvd;
    write_cfg(8'hEC);
    check_eq("R9 reserved bits read 0", cfg_rdata, 8'h80);
    hold_level(1'b0, 20, "R9 reserved bits leave pin");
  endtask

  task automatic t_rates;
    write_cfg(8'h13);
    idle(80);
    measure_half(1, "R4 code 11 half period");
    write_cfg(8'h12);
    idle(80);
    measure_half(4, "R4 code 10 half period");
    write_cfg(8'h11);
    idle(80);
    measure_half(8, "R4 code 01 half period");
    write_cfg(8'h10);
    idle(80);
    measure_half(1 << (CNT_W - 1), "R4 code 00 half period");
  endtask

  task automatic t_tick_gap;
    write_cfg(8'h12);
    idle(80);
    tick_gap = 2;
    idle(20);
    measure_half(8, "R5 code 10 with tick every 2nd cycle");
    tick_gap = 1;
    idle(20);
  endtask

  task automatic wait_strobe(output int waited);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!sec_strobe && waited < 1000);
  endtask

  task automatic t_second;
    int w;
    write_cfg(8'h13);
    idle(10);
    wait_strobe(w);
    @(negedge clk);
    check_eq("R6 strobe width", sec_strobe, 0);
    wait_strobe(w);
    check_eq("R6 strobe period code 11", w + 1, 1 << CNT_W);
    write_cfg(8'h00);
    wait_strobe(w);
    wait_strobe(w);
    check_eq("R6 strobe period disabled", w, 1 << CNT_W);
  endtask

  task automatic t_align;
    logic prev;
    int   hits;
    int   t;
    write_cfg(8'h10);
    idle(80);
    hits = 0;
    t = 0;
    @(negedge clk);
    prev = sqw_pull_low;
    while (hits < 3 && t < 1000) begin
      @(negedge clk);
      t++;
      if (sec_strobe) begin
        hits++;
        check_eq("R7 strobe on wave falling edge", {prev, sqw_pull_low}, 2'b01);
      end
      prev = sqw_pull_low;
    end
    check_eq("R7 strobes seen", hits, 3);
  endtask

  task automatic t_switch;
    logic prev;
    logic cur;
    int   last;
    int   min_iv;
    bit   seen;
    for (int k = 0; k < 8; k++) begin
      write_cfg(8'h11);
      idle(30);
      min_iv = 1000;
      seen = 0;
      last = 0;
      @(negedge clk);
      prev = sqw_pull_low;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        cur = sqw_pull_low;
        if (cur != prev) begin
          if (seen && (c - last) < min_iv) min_iv = c - last;
          last = c;
          seen = 1;
        end
        prev = cur;
        if (c == 10 + k) begin
          cfg_we    = 1'b1;
          cfg_wdata = 8'h12;
        end else begin
          cfg_we = 1'b0;
        end
      end
      check_eq("R8 no runt on switch 01 to 10", (min_iv >= 4) ? 1 : 0, 1);
    end
    measure_half(4, "R8 new rate after switch");
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    done     = 0;
    t_reset();
    t_readback();
    t_static();
    t_rsvd();
    t_rates();
    t_tick_gap();
    t_second();
    t_align();
    t_switch();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule